// File: doc/BRIEF.md
# Scrambled SRAM Key and Access Gate

This block is the control core that sits in front of a scrambled SRAM. It obtains a fresh scrambling key and nonce from a key provider through a request/acknowledge exchange. It moves the acknowledged key onto its key outputs after a fixed delay, and it can fill the whole memory with pseudo-random words to initialise it. It also decides, request by request, whether a memory access may pass to the SRAM port or must be answered with an error.

Software drives a two-bit control write: one bit starts a key renewal and the other starts the initialisation sweep. A five-bit status word reports the block's condition. A lifecycle escalation input locks the block for good: once it has propagated, every access is refused, control writes are dropped and the key is marked invalid until reset. Each memory request carries a tag that marks it as an instruction fetch or a data access. Fetches pass only when the build allows execution and the runtime execute enable is high.

Top module: `sram_key_gate`

## Requirements
- R1: After reset the status word is 0, keyReq, keyValid, memGnt, memErr and sramReq are 0.
- R2: A control write with bit 0 set raises keyReq and clears keyValid (status bit 2) at the next clock edge; keyReq stays high until a cycle in which keyAck is high.
- R3: The key response word is packed with the seed-valid bit in the most significant position, then the key field, then the nonce field in the least significant bits; the seed-valid bit appears in status bit 3.
- R4: The key, the nonce and keyValid take their new values at the 4th clock edge after the edge that samples keyAck high, and not before.
- R5: escIn sampled high at edge E makes every request sampled at edge E+3 or later be refused; status bit 1 (escalated) rises and keyValid falls at edge E+3, and both hold until reset.
- R6: A request with memInstr high is granted only when the build parameter EXEC_EN is nonzero and execEnable is high, otherwise it gets memErr; data requests ignore execEnable.
- R7: Two builds are supported: a 15-bit word address with execution allowed (default) and a 10-bit word address with execution disabled; the sweep covers 2^ADDR_W words in each.
- R8: A request sampled while keyValid is low is refused with memErr.
- R9: A control write with bit 1 set, when no sweep is running, writes addresses 0, 1, 2, ... on the SRAM port one word per cycle with LFSR data; status bit 4 (init done) clears at the start and rises with the last write; requests during the sweep are refused.
- R10: Status bit 0 (error) rises with the first refused request and stays set until reset.
- R11: Control writes arriving while escalation is in effect have no effect: no key request and no sweep.
- R12: Each request receives exactly one of memGnt or memErr one cycle after it is sampled; without a request neither is asserted. A granted request appears on the SRAM port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWrEn | input | 1 | Control write strobe |
| ctrlWrData | input | 2 | Bit 0 renew key, bit 1 start sweep |
| statusOut | output | 5 | {initDone, seedValid, keyValid, escalated, error} |
| keyReq | output | 1 | Key request toward the key provider |
| keyAck | input | 1 | Key response acknowledge |
| keyRspData | input | 1+KEY_W+NONCE_W | {seedValid, key, nonce} |
| scrKey | output | KEY_W | Scrambling key |
| scrNonce | output | NONCE_W | Scrambling nonce |
| keyValid | output | 1 | Key usable |
| escIn | input | 1 | Lifecycle escalation request |
| execEnable | input | 1 | Runtime execute enable |
| memReq | input | 1 | Memory request |
| memInstr | input | 1 | 1 = instruction fetch, 0 = data |
| memWe | input | 1 | Write request |
| memAddr | input | ADDR_W | Word address |
| memWdata | input | DATA_W | Write data |
| memGnt | output | 1 | Request granted |
| memErr | output | 1 | Request refused |
| sramReq | output | 1 | SRAM access strobe |
| sramWe | output | 1 | SRAM write |
| sramAddr | output | ADDR_W | SRAM word address |
| sramWdata | output | DATA_W | SRAM write data |

## Verification
The hardest situation to reach from the ports is the boundary of the escalation delay, where a request one edge before the lock takes hold must still be granted and the next one refused. The stimulus holds a request high every cycle across the escalation pulse and checks each response edge by edge. The full sweep of the 15-bit build is also deep: the bench runs it to completion, counts every write on the SRAM port and compares each address with its expected position. It does the same for the 10-bit build, which runs alongside on the same inputs.

// File: rtl/sram_gate_pkg.sv
package sram_gate_pkg;

  // Strobes issued by the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic keyCapture;  // latch the key response word
    logic keyLoad;     // move latched key to the outputs
    logic initStart;   // reset sweep counter and LFSR
    logic initStep;    // emit one sweep write
    logic grant;       // forward the current request
    logic reject;      // answer the current request with an error
  } gateStrobe_t;

endpackage

// File: rtl/sram_gate_ctrl.sv
module sram_gate_ctrl
  import sram_gate_pkg::*;
#(
  parameter int EXEC_EN = 1,
  parameter int KEY_DLY = 4,
  parameter int ESC_DLY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [1:0]  ctrlWrData,
  input  logic        keyAck,
  input  logic        escIn,
  input  logic        execEnable,
  input  logic        memReq,
  input  logic        memInstr,
  input  logic        initLast,
  output logic        keyReq,
  output logic        keyValid,
  output logic        escalated,
  output logic        errSticky,
  output logic        initDone,
  output gateStrobe_t strb
);

  logic [ESC_DLY-1:0] escSr;
  logic [KEY_DLY-1:0] keyDly;
  logic initBusy;
  logic blocked;
  logic wrOk;
  logic renewReq;
  logic initReq;
  logic execOk;
  logic accessOk;

  // Escalation counts as effective once it has crossed the delay line.
  assign blocked  = escalated | escSr[ESC_DLY-1];
  assign wrOk     = ctrlWrEn && !blocked;
  assign renewReq = wrOk && ctrlWrData[0];
  assign initReq  = wrOk && ctrlWrData[1] && !initBusy;
  assign execOk   = (EXEC_EN != 0) && execEnable;
  assign accessOk = keyValid && !blocked && !initBusy && (!memInstr || execOk);

  always_comb begin
    strb            = '0;
    strb.keyCapture = keyReq && keyAck;
    strb.keyLoad    = keyDly[KEY_DLY-1];
    strb.initStart  = initReq;
    strb.initStep   = initBusy && !blocked;
    strb.grant      = memReq && accessOk;
    strb.reject     = memReq && !accessOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      escSr     <= '0;
      escalated <= 1'b0;
      keyDly    <= '0;
      keyReq    <= 1'b0;
      keyValid  <= 1'b0;
      errSticky <= 1'b0;
      initBusy  <= 1'b0;
      initDone  <= 1'b0;
    end else begin
      escSr     <= (escSr << 1) | ESC_DLY'(escIn);
      escalated <= blocked;
      keyDly    <= (keyDly << 1) | KEY_DLY'(strb.keyCapture);
      errSticky <= errSticky | strb.reject;

      if (renewReq)             keyReq <= 1'b1;
      else if (strb.keyCapture) keyReq <= 1'b0;

      if (blocked || renewReq)  keyValid <= 1'b0;
      else if (strb.keyLoad)    keyValid <= 1'b1;

      if (blocked)                       initBusy <= 1'b0;
      else if (initReq)                  initBusy <= 1'b1;
      else if (strb.initStep && initLast) initBusy <= 1'b0;

      if (initReq)                       initDone <= 1'b0;
      else if (strb.initStep && initLast) initDone <= 1'b1;
    end
  end

  // R2: a pending key request is held until acknowledged
  p_keyreq_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    keyReq && !keyAck |=> keyReq);

  // R5: escalation lock is sticky
  p_esc_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    escalated |=> escalated);

  // R10: error flag never falls outside reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R5: no valid key while locked
  p_no_key_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    escalated |-> !keyValid);

endmodule

// File: rtl/sram_gate_dp.sv
module sram_gate_dp
  import sram_gate_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 64,
  parameter int NONCE_W = 32,
  parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003,
  parameter logic [DATA_W-1:0] LFSR_SEED = 32'h0000_0001,
  localparam int RSP_W = 1 + KEY_W + NONCE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStrobe_t        strb,
  input  logic [RSP_W-1:0]   keyRspData,
  input  logic               memWe,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memWdata,
  output logic               initLast,
  output logic [KEY_W-1:0]   scrKey,
  output logic [NONCE_W-1:0] scrNonce,
  output logic               seedValid,
  output logic               memGnt,
  output logic               memErr,
  output logic               sramReq,
  output logic               sramWe,
  output logic [ADDR_W-1:0]  sramAddr,
  output logic [DATA_W-1:0]  sramWdata
);

  logic               holdSeed;
  logic [KEY_W-1:0]   holdKey;
  logic [NONCE_W-1:0] holdNonce;
  logic [ADDR_W-1:0]  initCnt;
  logic [DATA_W-1:0]  lfsr;
  logic [DATA_W-1:0]  lfsrNext;

  assign initLast = &initCnt;
  assign lfsrNext = {lfsr[DATA_W-2:0], ^(lfsr & LFSR_TAPS)};

  // Key staging: latched on acknowledge, published on the delayed strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdSeed  <= 1'b0;
      holdKey   <= '0;
      holdNonce <= '0;
      scrKey    <= '0;
      scrNonce  <= '0;
      seedValid <= 1'b0;
    end else begin
      if (strb.keyCapture) begin
        holdSeed  <= keyRspData[RSP_W-1];
        holdKey   <= keyRspData[RSP_W-2 -: KEY_W];
        holdNonce <= keyRspData[NONCE_W-1:0];
      end
      if (strb.keyLoad) begin
        scrKey    <= holdKey;
        scrNonce  <= holdNonce;
        seedValid <= holdSeed;
      end
    end
  end

  // Sweep counter, data source and SRAM port registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initCnt   <= '0;
      lfsr      <= LFSR_SEED;
      memGnt    <= 1'b0;
      memErr    <= 1'b0;
      sramReq   <= 1'b0;
      sramWe    <= 1'b0;
      sramAddr  <= '0;
      sramWdata <= '0;
    end else begin
      memGnt  <= strb.grant;
      memErr  <= strb.reject;
      sramReq <= strb.grant | strb.initStep;
      if (strb.initStart) begin
        initCnt <= '0;
        lfsr    <= LFSR_SEED;
      end else if (strb.initStep) begin
        initCnt <= initCnt + ADDR_W'(1);
        lfsr    <= lfsrNext;
      end
      if (strb.initStep) begin
        sramWe    <= 1'b1;
        sramAddr  <= initCnt;
        sramWdata <= lfsr;
      end else if (strb.grant) begin
        sramWe    <= memWe;
        sramAddr  <= memAddr;
        sramWdata <= memWdata;
      end
    end
  end

  // R4: key outputs move only on the delayed load strobe
  p_key_only_on_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.keyLoad |=> $stable(scrKey) && $stable(scrNonce));

  // R12: never both responses
  p_one_resp_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(memGnt && memErr));

  // R9: back-to-back sweep writes walk upward by one
  p_sweep_ascending_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.initStep) && $past(strb.initStep, 2) |-> sramAddr == $past(sramAddr) + ADDR_W'(1));

endmodule

// File: rtl/sram_key_gate.sv
module sram_key_gate
  import sram_gate_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int EXEC_EN = 1,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 64,
  parameter int NONCE_W = 32,
  parameter int KEY_DLY = 4,
  parameter int ESC_DLY = 3,
  parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003,
  parameter logic [DATA_W-1:0] LFSR_SEED = 32'h0000_0001,
  localparam int RSP_W = 1 + KEY_W + NONCE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [1:0]         ctrlWrData,
  output logic [4:0]         statusOut,
  output logic               keyReq,
  input  logic               keyAck,
  input  logic [RSP_W-1:0]   keyRspData,
  output logic [KEY_W-1:0]   scrKey,
  output logic [NONCE_W-1:0] scrNonce,
  output logic               keyValid,
  input  logic               escIn,
  input  logic               execEnable,
  input  logic               memReq,
  input  logic               memInstr,
  input  logic               memWe,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memWdata,
  output logic               memGnt,
  output logic               memErr,
  output logic               sramReq,
  output logic               sramWe,
  output logic [ADDR_W-1:0]  sramAddr,
  output logic [DATA_W-1:0]  sramWdata
);

  gateStrobe_t strb;
  logic initLast;
  logic escalated;
  logic errSticky;
  logic initDone;
  logic seedValid;

  sram_gate_ctrl #(
    .EXEC_EN(EXEC_EN), .KEY_DLY(KEY_DLY), .ESC_DLY(ESC_DLY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .keyAck(keyAck), .escIn(escIn), .execEnable(execEnable),
    .memReq(memReq), .memInstr(memInstr), .initLast(initLast),
    .keyReq(keyReq), .keyValid(keyValid), .escalated(escalated),
    .errSticky(errSticky), .initDone(initDone), .strb(strb)
  );

  sram_gate_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .NONCE_W(NONCE_W),
    .LFSR_TAPS(LFSR_TAPS), .LFSR_SEED(LFSR_SEED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .keyRspData(keyRspData),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .initLast(initLast), .scrKey(scrKey), .scrNonce(scrNonce),
    .seedValid(seedValid), .memGnt(memGnt), .memErr(memErr),
    .sramReq(sramReq), .sramWe(sramWe), .sramAddr(sramAddr), .sramWdata(sramWdata)
  );

  assign statusOut = {initDone, seedValid, keyValid, escalated, errSticky};

  // R5: once the escalated bit shows, nothing is granted
  p_esc_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[1] |-> !memGnt);

  // R6: fetches pass only under the execute policy
  p_instr_policy_r6: assert property (@(posedge clk) disable iff (!rstN)
    memGnt && $past(memInstr) |-> (EXEC_EN != 0) && $past(execEnable));

  // R8: a grant requires a valid key when sampled
  p_grant_needs_key_r8: assert property (@(posedge clk) disable iff (!rstN)
    memGnt |-> $past(keyValid));

  // R12: responses only follow a request
  p_resp_needs_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    memGnt || memErr |-> $past(memReq));

endmodule

// File: tb/sram_key_gate_bench.sv
module sram_key_gate_bench;

  localparam logic [63:0] K1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [31:0] N1 = 32'hCAFE_F00D;
  localparam logic [63:0] K2 = 64'hFEDC_BA98_7654_3210;
  localparam logic [31:0] N2 = 32'h1357_9BDF;

  // {instr, we, execEnable, gntMain, errMain, gntRet, errRet}
  localparam logic [6:0] VEC [6] = '{
    7'b000_1010, 7'b010_1010, 7'b100_0101,
    7'b101_1001, 7'b001_1010, 7'b111_1001 };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [1:0] ctrlWrData = '0;
  logic keyAck = 1'b0;
  logic [96:0] keyRspData = '0;
  logic escIn = 1'b0;
  logic execEnable = 1'b0;
  logic memReq = 1'b0;
  logic memInstr = 1'b0;
  logic memWe = 1'b0;
  logic [14:0] memAddr = '0;
  logic [31:0] memWdata = '0;

  logic [4:0] statM, statR;
  logic keyReqM, keyReqR, keyValidM, keyValidR;
  logic [63:0] scrKeyM, scrKeyR;
  logic [31:0] scrNonceM, scrNonceR;
  logic gntM, errM, gntR, errR;
  logic sramReqM, sramWeM, sramReqR, sramWeR;
  logic [14:0] sramAddrM;
  logic [9:0] sramAddrR;
  logic [31:0] sramWdataM, sramWdataR;

  int checks = 0;
  int fails = 0;
  bit sweepOn = 1'b0;
  int cntM = 0, cntR = 0, addrErrM = 0, addrErrR = 0;

  always #2 clk = ~clk;

  sram_key_gate u_sram_key_gate (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statusOut(statM), .keyReq(keyReqM), .keyAck(keyAck), .keyRspData(keyRspData),
    .scrKey(scrKeyM), .scrNonce(scrNonceM), .keyValid(keyValidM),
    .escIn(escIn), .execEnable(execEnable), .memReq(memReq), .memInstr(memInstr),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memGnt(gntM), .memErr(errM), .sramReq(sramReqM), .sramWe(sramWeM),
    .sramAddr(sramAddrM), .sramWdata(sramWdataM));

  sram_key_gate #(.ADDR_W(10), .EXEC_EN(0)) u_ret (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statusOut(statR), .keyReq(keyReqR), .keyAck(keyAck), .keyRspData(keyRspData),
    .scrKey(scrKeyR), .scrNonce(scrNonceR), .keyValid(keyValidR),
    .escIn(escIn), .execEnable(execEnable), .memReq(memReq), .memInstr(memInstr),
    .memWe(memWe), .memAddr(memAddr[9:0]), .memWdata(memWdata),
    .memGnt(gntR), .memErr(errR), .sramReq(sramReqR), .sramWe(sramWeR),
    .sramAddr(sramAddrR), .sramWdata(sramWdataR));

  // Sweep monitor: counts writes and checks address order mid-cycle.
  always @(negedge clk) begin
    if (sweepOn) begin
      if (sramReqM) begin
        if (sramAddrM != cntM[14:0] || !sramWeM) addrErrM++;
        cntM++;
      end
      if (sramReqR) begin
        if (sramAddrR != cntR[9:0] || !sramWeR) addrErrR++;
        cntR++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
  endtask

  task automatic deliverKey(input logic seed, input logic [63:0] k, input logic [31:0] n);
    keyAck = 1'b1;
    keyRspData = {seed, k, n};
    step();                          // edge A samples the acknowledge
    keyAck = 1'b0;
    chk("R2 keyReq drops on ack", 64'(keyReqM), 64'd0);
    for (int i = 1; i < 4; i++) begin
      step();
      chk("R4 key not yet valid", 64'(keyValidM), 64'd0);
    end
    step();                          // edge A+4
    chk("R4 keyValid at 4th edge", 64'(keyValidM), 64'd1);
    chk("R3 key field", scrKeyM, k);
    chk("R3 nonce field", 64'(scrNonceM), 64'(n));
    chk("R3 seed bit in status bit 3", 64'(statM[3]), 64'(seed));
    chk("R4 ret build key", scrKeyR, k);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    doReset();
    // R1 reset state
    chk("R1 status main", 64'(statM), 64'd0);
    chk("R1 status ret", 64'(statR), 64'd0);
    chk("R1 outputs idle", 64'({keyReqM, keyValidM, gntM, errM, sramReqM}), 64'd0);

    // R8 / R10: access before any key
    memReq = 1'b1;
    step();
    memReq = 1'b0;
    chk("R8 no key refuses", 64'({gntM, errM}), 64'b01);
    chk("R10 error bit set", 64'(statM[0]), 64'd1);

    // R2 renewal request
    ctrlWrEn = 1'b1; ctrlWrData = 2'b01;
    step();
    ctrlWrEn = 1'b0; ctrlWrData = 2'b00;
    chk("R2 keyReq raised", 64'(keyReqM), 64'd1);
    repeat (3) step();
    chk("R2 keyReq held", 64'(keyReqM), 64'd1);
    deliverKey(1'b1, K1, N1);
    chk("R10 error still set", 64'(statM[0]), 64'd1);

    // R6 / R12 vector walk
    for (int i = 0; i < 6; i++) begin
      logic vi, vw, vx, gm, em, gr, er;
      {vi, vw, vx, gm, em, gr, er} = VEC[i];
      memReq = 1'b1; memInstr = vi; memWe = vw; execEnable = vx;
      memAddr = 15'(i * 37 + 5); memWdata = 32'hA5A5_0000 + i;
      step();
      memReq = 1'b0;
      chk("R6 main response", 64'({gntM, errM}), 64'({gm, em}));
      chk("R6 ret response", 64'({gntR, errR}), 64'({gr, er}));
      if (gm) chk("R12 forwarded on SRAM port", 64'({sramReqM, sramWeM, sramAddrM}),
                  64'({1'b1, vw, memAddr}));
      step();
      chk("R12 idle without request", 64'({gntM, errM, gntR, errR}), 64'd0);
    end
    memInstr = 1'b0; memWe = 1'b0;

    // R9 / R7 initialisation sweep
    sweepOn = 1'b1;
    ctrlWrEn = 1'b1; ctrlWrData = 2'b10;
    step();
    ctrlWrEn = 1'b0; ctrlWrData = 2'b00;
    chk("R9 init done low at start", 64'(statM[4]), 64'd0);
    memReq = 1'b1;
    step();
    memReq = 1'b0;
    chk("R9 request refused during sweep", 64'({gntM, errM}), 64'b01);
    for (int i = 0; i < 2000 && !statR[4]; i++) step();
    step();
    chk("R7 ret sweep word count", 64'(cntR), 64'd1024);
    chk("R9 ret sweep address order", 64'(addrErrR), 64'd0);
    chk("R9 main still sweeping", 64'(statM[4]), 64'd0);
    for (int i = 0; i < 40000 && !statM[4]; i++) step();
    step();
    sweepOn = 1'b0;
    chk("R7 main sweep word count", 64'(cntM), 64'd32768);
    chk("R9 main sweep address order", 64'(addrErrM), 64'd0);
    chk("R9 init done set", 64'(statM[4]), 64'd1);

    // R2 / R8 second renewal
    ctrlWrEn = 1'b1; ctrlWrData = 2'b01;
    step();
    ctrlWrEn = 1'b0; ctrlWrData = 2'b00;
    chk("R2 keyValid cleared by renew", 64'({keyValidM, statM[2]}), 64'd0);
    memReq = 1'b1;
    step();
    memReq = 1'b0;
    chk("R8 refused while renewing", 64'({gntM, errM}), 64'b01);
    deliverKey(1'b0, K2, N2);

    // R5 escalation edge by edge
    escIn = 1'b1; memReq = 1'b1;
    step();                          // edge E
    escIn = 1'b0;
    chk("R5 grant at E", 64'({gntM, errM}), 64'b10);
    step();
    chk("R5 grant at E+1", 64'({gntM, errM}), 64'b10);
    step();
    chk("R5 grant at E+2", 64'({gntM, errM, statM[1]}), 64'b100);
    step();
    chk("R5 refused at E+3", 64'({gntM, errM}), 64'b01);
    chk("R5 escalated set, key invalid", 64'({statM[1], keyValidM}), 64'b10);
    step();
    memReq = 1'b0;
    chk("R5 still refused", 64'({gntM, errM}), 64'b01);
    repeat (5) step();
    chk("R5 lock sticky", 64'(statM[1]), 64'd1);

    // R11 control writes ignored while locked
    ctrlWrEn = 1'b1; ctrlWrData = 2'b11;
    sweepOn = 1'b1; cntM = 0;
    step();
    ctrlWrEn = 1'b0; ctrlWrData = 2'b00;
    repeat (5) step();
    sweepOn = 1'b0;
    chk("R11 no key request", 64'(keyReqM), 64'd0);
    chk("R11 no sweep writes", 64'(cntM), 64'd0);
    chk("R11 init done unchanged", 64'(statM[4]), 64'd1);

    // R1 / R5 leaving the lock by reset
    doReset();
    chk("R5 reset clears lock", 64'(statM), 64'd0);
    finishRun();
  end

endmodule